// File: doc/BRIEF.md
# Multi-Mode Watchdog Timer

This block is a watchdog timer that counts ticks from a slow, separate oscillator. The ticks reach it as a one-cycle enable on the system clock. Software picks a timeout length with a 4-bit select and turns on either or both of two actions. The first action raises an interrupt flag. The second sends a one-cycle system reset pulse. With both turned on, the first timeout raises the flag and turns the interrupt action off, so a second timeout with no restart in between resets the system.

A restart strobe sets the tick count back to zero. Two kinds of configuration change are protected: clearing the reset action and changing the timeout select. Software must first make an unlock write. The protected write must then arrive within the next `UNLOCK_WIN` system clocks. A protected write outside that window changes nothing. The oscillator, any forced-enable option and the reset stretching logic sit outside this block.

All pins are plain control and status signals. There is no streaming data interface, so there is no valid/ready handshake.

Top module: `wdog_timer`

## Requirements
- R1: After reset `irq_flag` and `wdt_reset` are 0, both actions are off and the select is 0. While both actions are off the count is held at zero and no timeout occurs.
- R2: With an action on, a timeout occurs on the tick that brings the count to 2^BASE_LOG2 << sel. Each step of sel doubles the period. The outputs change on the same clock edge that samples that tick, and the count then restarts from zero.
- R3: A sel value above MAX_SEL gives the same period as MAX_SEL.
- R4: `kick` high at a clock edge sets the count to zero, and no timeout occurs on that edge. A cycle with `wd_tick` low leaves the count unchanged.
- R5: Interrupt-only mode (irq on, reset off): each timeout sets `irq_flag`. No reset pulse is sent, and the timer keeps running.
- R6: Reset-only mode (reset on, irq off): each timeout drives `wdt_reset` high for exactly one clock. `irq_flag` is not set.
- R7: Combined mode: the first timeout sets `irq_flag`, sends no pulse and turns the irq action off. A later timeout then sends the reset pulse. If a write sets irq on in the same cycle as this turn-off, the turn-off wins.
- R8: A write made outside the unlock window sets the irq action to `cfg_irq_en` and can turn the reset action on. It cannot turn the reset action off, and it does not change the select.
- R9: A write with `cfg_unlock`=1 changes no setting and opens a window. A write in any of the next UNLOCK_WIN (4) cycles applies all fields and closes the window. A write one cycle later is treated as outside the window.
- R10: `irq_flag` stays set until `flag_clr` is high at a clock edge. If a timeout that sets the flag happens on that same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| kick | input | 1 | Restart strobe, clears the count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unlock | input | 1 | Unlock write (opens the change window) |
| cfg_rst_en | input | 1 | Write value: reset action on |
| cfg_irq_en | input | 1 | Write value: interrupt action on |
| cfg_sel | input | SEL_W | Write value: timeout select |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| wdt_reset | output | 1 | One-cycle system reset pulse |

## Verification
The assertions assume that `wd_tick`, `kick`, `cfg_we` and `flag_clr` are synchronous to `clk` and never X once reset is released. They also assume that any combination of these may occur in the same cycle, including a tick during a write or a restart, so every priority rule is exercised. The random stimulus draws each input independently per cycle from a fixed seed. Writes are rare, and half of them are unlock writes, so protected writes land both inside and outside the window. The short bench periods produce many timeouts in every mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic rst_en;
    logic irq_en;
  } wdt_mode_t;

  function automatic int unsigned clamp_sel(input int unsigned sel, input int unsigned max_sel);
    return (sel > max_sel) ? max_sel : sel;
  endfunction
endpackage

// File: rtl/wdt_cfg_guard.sv
module wdt_cfg_guard
  import wdt_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int UNLOCK_WIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             unlock_i,
  input  logic             rst_en_i,
  input  logic             irq_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             timeout_i,
  output wdt_mode_t        mode_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int WIN_W = $clog2(UNLOCK_WIN + 1);

  logic [WIN_W-1:0] win_q;
  wdt_mode_t        mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             win_open;
  logic             escalate;

  assign win_open = (win_q != '0);
  // combined mode: first timeout hands over from interrupt to reset
  assign escalate = timeout_i && mode_q.irq_en && mode_q.rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      mode_q <= '0;
      sel_q  <= '0;
    end else begin
      if (we_i && unlock_i) begin
        win_q <= WIN_W'(UNLOCK_WIN);
      end else if (we_i && win_open) begin
        mode_q.rst_en <= rst_en_i;
        mode_q.irq_en <= irq_en_i;
        sel_q         <= sel_i;
        win_q         <= '0;
      end else begin
        if (we_i) begin
          mode_q.irq_en <= irq_en_i;
          mode_q.rst_en <= mode_q.rst_en | rst_en_i;
        end
        if (win_open) win_q <= win_q - 1'b1;
      end
      if (escalate) mode_q.irq_en <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;

  assert_sel_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !unlock_i && !win_open) |=> (sel_q == $past(sel_q)));
  assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && mode_q.rst_en) |=> mode_q.rst_en);
  assert_window_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !(we_i && unlock_i)) |=> !win_open);
  assert_escalate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    escalate |=> !mode_q.irq_en);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int SEL_W     = 4,
  parameter int BASE_LOG2 = 11,
  parameter int MAX_SEL   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  localparam int CNT_W = BASE_LOG2 + MAX_SEL + 1;
  localparam logic [CNT_W-1:0] BASE_CNT = CNT_W'(1) << BASE_LOG2;
  localparam logic [CNT_W-1:0] MAX_CNT  = BASE_CNT << MAX_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] limit;
  logic [SEL_W-1:0] eff_sel;

  always_comb begin
    eff_sel = (int'(sel_i) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel_i;
    limit   = BASE_CNT << eff_sel;
    cnt_inc = cnt_q + 1'b1;
  end

  assign timeout_o = active_i && tick_i && !kick_i && (cnt_inc >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (kick_i || !active_i) cnt_q <= '0;
    else if (tick_i)              cnt_q <= timeout_o ? '0 : cnt_inc;
  end

  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0));
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !tick_i && !kick_i) |=> (cnt_q == $past(cnt_q)));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < MAX_CNT);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      timeout_i,
  input  wdt_mode_t mode_i,
  input  logic      flag_clr_i,
  output logic      irq_flag_o,
  output logic      reset_o
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= timeout_i && mode_i.rst_en && !mode_i.irq_en;
      if (timeout_i && mode_i.irq_en) flag_q <= 1'b1;
      else if (flag_clr_i)            flag_q <= 1'b0;
    end
  end

  assign irq_flag_o = flag_q;
  assign reset_o    = pulse_q;

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_no_pulse_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i && mode_i.irq_en) |=> (flag_q && !pulse_q));
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int BASE_LOG2  = 11,
  parameter int MAX_SEL    = 9,
  parameter int UNLOCK_WIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_tick,
  input  logic             kick,
  input  logic             cfg_we,
  input  logic             cfg_unlock,
  input  logic             cfg_rst_en,
  input  logic             cfg_irq_en,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             flag_clr,
  output logic             irq_flag,
  output logic             wdt_reset
);
  wdt_mode_t        mode;
  logic [SEL_W-1:0] sel;
  logic             timeout;

  wdt_cfg_guard #(.SEL_W(SEL_W), .UNLOCK_WIN(UNLOCK_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .unlock_i(cfg_unlock),
    .rst_en_i(cfg_rst_en), .irq_en_i(cfg_irq_en), .sel_i(cfg_sel),
    .timeout_i(timeout), .mode_o(mode), .sel_o(sel)
  );

  wdt_counter #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .MAX_SEL(MAX_SEL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active_i(mode.rst_en | mode.irq_en),
    .tick_i(wd_tick), .kick_i(kick), .sel_i(sel), .timeout_o(timeout)
  );

  wdt_action u_act (
    .clk(clk), .rst_n(rst_n), .timeout_i(timeout), .mode_i(mode),
    .flag_clr_i(flag_clr), .irq_flag_o(irq_flag), .reset_o(wdt_reset)
  );

  assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode.rst_en | mode.irq_en) |=> !wdt_reset);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int SEL_W = 4, BASE_LOG2 = 2, MAX_SEL = 3, WIN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wd_tick = 0, kick = 0, cfg_we = 0, cfg_unlock = 0, cfg_rst_en = 0, cfg_irq_en = 0, flag_clr = 0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic irq_flag, wdt_reset;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_cnt, m_win, m_sel;
  bit m_rst, m_irq, m_flag, m_pulse;

  always #2 clk = ~clk;

  wdog_timer #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .MAX_SEL(MAX_SEL), .UNLOCK_WIN(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .kick(kick), .cfg_we(cfg_we),
    .cfg_unlock(cfg_unlock), .cfg_rst_en(cfg_rst_en), .cfg_irq_en(cfg_irq_en),
    .cfg_sel(cfg_sel), .flag_clr(flag_clr), .irq_flag(irq_flag), .wdt_reset(wdt_reset));

  function automatic int period(input int sel);
    int s = (sel > MAX_SEL) ? MAX_SEL : sel;
    return (1 << BASE_LOG2) << s;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit act = m_rst | m_irq;
    bit to = act && wd_tick && !kick && (m_cnt + 1 >= period(m_sel));
    bit esc = to && m_irq && m_rst;
    m_pulse = to && m_rst && !m_irq;
    if (to && m_irq) m_flag = 1; else if (flag_clr) m_flag = 0;
    if (kick || !act) m_cnt = 0; else if (wd_tick) m_cnt = to ? 0 : m_cnt + 1;
    if (cfg_we && cfg_unlock) m_win = WIN;
    else if (cfg_we && m_win != 0) begin
      m_rst = cfg_rst_en; m_irq = cfg_irq_en; m_sel = cfg_sel; m_win = 0;
    end else begin
      if (cfg_we) begin m_irq = cfg_irq_en; m_rst = m_rst | cfg_rst_en; end
      if (m_win != 0) m_win--;
    end
    if (esc) m_irq = 0;
  endtask

  // inputs already driven at a negedge; advance one clock and compare
  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check({tag, " irq_flag"}, irq_flag, m_flag);
    check({tag, " wdt_reset"}, wdt_reset, m_pulse);
    wd_tick = 0; kick = 0; cfg_we = 0; cfg_unlock = 0; flag_clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_cnt = 0; m_win = 0; m_sel = 0; m_rst = 0; m_irq = 0; m_flag = 0; m_pulse = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input bit unl, input bit r, input bit i, input int s);
    cfg_we = 1; cfg_unlock = unl; cfg_rst_en = r; cfg_irq_en = i; cfg_sel = SEL_W'(s);
    cyc(tag);
  endtask

  task automatic ticks(input string tag, input int n);
    for (int k = 0; k < n; k++) begin wd_tick = 1; cyc(tag); end
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) cyc(tag);
  endtask

  // restart, then count ticks until the chosen output goes high
  task automatic measure(input string tag, input bit want_pulse, input int exp);
    int n = 0;
    bit seen = 0;
    flag_clr = 1; kick = 1; cyc(tag);
    while (!seen && n < 200) begin
      wd_tick = 1; cyc(tag); n++;
      seen = want_pulse ? wdt_reset : irq_flag;
    end
    check({tag, " period"}, n, exp);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    check("R1 reset irq_flag", irq_flag, 0);
    check("R1 reset wdt_reset", wdt_reset, 0);
    ticks("R1 stopped", 50);

    // interrupt-only mode
    wr("R8 irq on", 0, 0, 1, 0);
    measure("R2 R5 sel0", 0, period(0));
    ticks("R5 no pulse, flag held R10", 10);
    check("R10 flag held", irq_flag, 1);
    flag_clr = 1; cyc("R10 clear");
    check("R10 cleared", irq_flag, 0);

    // protected select change inside window
    wr("R9 unlock", 1, 0, 0, 3);
    check("R9 unlock has no effect", m_irq, 1);
    wr("R9 in window", 0, 0, 1, 2);
    measure("R2 sel2", 0, period(2));
    wr("R8 unprotected sel", 0, 0, 1, 1);
    measure("R8 sel ignored", 0, period(2));

    // window edge
    wr("R9 unlock", 1, 0, 1, 0);
    idle("R9 wait", WIN);
    wr("R9 late write", 0, 0, 1, 0);
    measure("R9 late ignored", 0, period(2));
    wr("R9 unlock", 1, 0, 1, 0);
    idle("R9 wait", WIN - 1);
    wr("R9 last slot", 0, 0, 1, 1);
    measure("R9 last slot applied", 0, period(1));

    // reserved selects
    wr("R3 unlock", 1, 0, 1, 0);
    wr("R3 sel9", 0, 0, 1, 9);
    measure("R3 sel9", 0, period(MAX_SEL));
    wr("R3 unlock", 1, 0, 1, 0);
    wr("R3 sel15", 0, 0, 1, 15);
    measure("R3 sel15", 0, period(MAX_SEL));

    // restart
    flag_clr = 1; cyc("R4 clr");
    ticks("R4 partial", period(MAX_SEL) - 2);
    kick = 1; wd_tick = 1; cyc("R4 kick with tick");
    idle("R4 no tick hold", 5);
    ticks("R4 after kick", period(MAX_SEL) - 1);
    check("R4 not yet", irq_flag, 0);
    ticks("R4 expiry", 1);
    check("R4 expiry", irq_flag, 1);

    // reset-only mode
    do_reset();
    wr("R6 reset on", 0, 1, 0, 0);
    measure("R6 pulse period", 1, period(0));
    check("R6 no flag", irq_flag, 0);
    idle("R6 one cycle", 1);
    check("R6 pulse width", wdt_reset, 0);
    wr("R8 clear rst unprotected", 0, 0, 0, 0);
    measure("R8 rst stays", 1, period(0));

    // combined mode
    do_reset();
    wr("R7 both on", 0, 1, 1, 0);
    ticks("R7 first", period(0));
    check("R7 first flag", irq_flag, 1);
    check("R7 first no pulse", wdt_reset, 0);
    ticks("R7 second", period(0));
    check("R7 second pulse", wdt_reset, 1);

    // flag clear racing a timeout
    do_reset();
    wr("R10 irq on", 0, 0, 1, 0);
    ticks("R10 pre", period(0) - 1);
    wd_tick = 1; flag_clr = 1; cyc("R10 race");
    check("R10 set wins", irq_flag, 1);

    // random phase, checked every cycle against the reference
    do_reset();
    for (int k = 0; k < 6000; k++) begin
      wd_tick  = ($urandom % 2) == 0;
      kick     = ($urandom % 40) == 0;
      flag_clr = ($urandom % 12) == 0;
      if (($urandom % 15) == 0) begin
        cfg_we = 1; cfg_unlock = ($urandom % 2) == 0;
        cfg_rst_en = ($urandom % 3) == 0; cfg_irq_en = ($urandom % 2) == 0;
        cfg_sel = SEL_W'($urandom);
      end
      cyc("R2 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule